// File: doc/BRIEF.md
# CPU-to-CSR Bus Width Down-Converter

This block sits between a wide CPU memory port and a narrow control/status register bus. The CPU port carries words of `CPU_DW` bits; the register bus carries chunks of `CSR_DW` bits, and `CPU_DW` is a whole multiple of `CSR_DW`. Every CPU access becomes a run of `RATIO = CPU_DW / CSR_DW` register-bus strobes on consecutive cycles. The run starts at the lowest chunk and targets consecutive chunk addresses.

On a write, each strobe carries one slice of the CPU word. The final strobe is the one that makes the register multiplexer commit the wide register. The CPU acknowledge therefore coincides with it.

On a read, the strobes are pipelined one per cycle. Each returned chunk is captured one cycle after its strobe, because the register bus delivers read data one cycle late. The captured chunks are assembled into a full word. That word is presented with the acknowledge one cycle after the last chunk is captured.

The CPU holds its request and its inputs stable until it sees the acknowledge. The block accepts no new request while a conversion is in progress.

Top module: `csr_width_dc`

## Requirements
- R1: While `rst_ni` is low, `ack_o`, `csr_r_stb_o` and `csr_w_stb_o` are all 0.
- R2: Each accepted CPU access produces exactly `RATIO` register-bus strobes (4 with defaults) on consecutive cycles. The first strobe comes in the cycle after the accepting clock edge.
- R3: Chunk i of an access targets `csr_addr_o = addr_i * RATIO + i`, and chunks are issued with i ascending from 0.
- R4: A write strobe for chunk i carries `wdata_i[i*CSR_DW +: CSR_DW]` on `csr_w_data_o` in the same cycle that `csr_w_stb_o` is high.
- R5: On a read, bits `[i*CSR_DW +: CSR_DW]` of `rdata_o` equal the `csr_r_data_i` value present in the cycle after chunk i's strobe.
- R6: For a write, `ack_o` is high in the cycle of the last write strobe. A 24-bit register behind four chunk addresses is therefore committed by the fourth write, in the acknowledge cycle.
- R7: For a read, `ack_o` is high exactly two cycles after the last read strobe, which is one cycle after the last chunk is captured.
- R8: `ack_o` is a single-cycle pulse. No strobe is issued while no access is in progress, and a request held high during a conversion starts nothing extra.
- R9: `csr_r_stb_o` and `csr_w_stb_o` are never high in the same cycle, and one access uses only one kind of strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | CPU request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | CPU_AW | CPU word address |
| wdata_i | input | CPU_DW | CPU write word, held until `ack_o` |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | CPU_DW | Assembled read word, valid with `ack_o` on reads |
| csr_addr_o | output | CSR_AW | Register-bus chunk address |
| csr_r_stb_o | output | 1 | Register-bus read strobe |
| csr_r_data_i | input | CSR_DW | Register-bus read data, valid the cycle after `csr_r_stb_o` |
| csr_w_stb_o | output | 1 | Register-bus write strobe |
| csr_w_data_o | output | CSR_DW | Register-bus write data, valid with `csr_w_stb_o` |

## Verification
A wrong chunk counter shows on the very next strobe: the address steps by something other than one, a strobe is missing, or an extra strobe reaches the register model with no expected entry queued. A wrong capture slot or capture cycle only becomes visible at the read acknowledge. There the assembled word holds misplaced bytes, or bytes read a cycle early or late, when compared with the bench's memory image. A wrong acknowledge cycle is caught by counting cycles from request to acknowledge. For a write, an early acknowledge also appears as the wide register's committed value being stale.

// File: rtl/csr_dc_pkg.sv
package csr_dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_RACK  = 2'd3
  } dc_state_e;
endpackage

// File: rtl/csr_dc_seq.sv
module csr_dc_seq #(
  parameter int CPU_AW = 6,
  parameter int RATIO  = 4,
  parameter int IW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [CPU_AW-1:0] addr_i,
  output logic              issue_o,
  output logic              we_o,
  output logic [IW-1:0]     idx_o,
  output logic [CPU_AW-1:0] base_o,
  output logic              ack_o
);
  import csr_dc_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(RATIO - 1);

  dc_state_e         state_q;
  logic [IW-1:0]     idx_q;
  logic              we_q;
  logic [CPU_AW-1:0] base_q;
  logic              last;

  assign last = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      we_q    <= 1'b0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_ISSUE;
          idx_q   <= '0;
          we_q    <= we_i;
          base_q  <= addr_i;
        end
        ST_ISSUE: begin
          if (last) begin
            idx_q   <= '0;
            state_q <= we_q ? ST_IDLE : ST_DRAIN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        // last read chunk lands at the end of this cycle
        ST_DRAIN: state_q <= ST_RACK;
        ST_RACK:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue_o = (state_q == ST_ISSUE);
  assign we_o    = we_q;
  assign idx_o   = idx_q;
  assign base_o  = base_q;
  assign ack_o   = (issue_o && we_q && last) || (state_q == ST_RACK);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX); // R2
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R8
endmodule

// File: rtl/csr_dc_wsel.sv
module csr_dc_wsel #(
  parameter int CPU_DW = 32,
  parameter int CSR_DW = 8,
  parameter int RATIO  = 4,
  parameter int IW     = 2
) (
  input  logic [CPU_DW-1:0] wdata_i,
  input  logic [IW-1:0]     idx_i,
  output logic [CSR_DW-1:0] chunk_o
);
  logic [CSR_DW-1:0] chunks [RATIO];

  for (genvar g = 0; g < RATIO; g++) begin : g_slice
    assign chunks[g] = wdata_i[g*CSR_DW +: CSR_DW];
  end

  always_comb begin
    chunk_o = '0;
    for (int i = 0; i < RATIO; i++) begin
      if (idx_i == IW'(i)) chunk_o = chunks[i];
    end
  end
endmodule

// File: rtl/csr_dc_rasm.sv
module csr_dc_rasm #(
  parameter int CPU_DW = 32,
  parameter int CSR_DW = 8,
  parameter int RATIO  = 4,
  parameter int IW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              r_stb_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [CSR_DW-1:0] r_data_i,
  output logic [CPU_DW-1:0] word_o
);
  logic              cap_vld_q;
  logic [IW-1:0]     cap_idx_q;
  logic [CSR_DW-1:0] slot_q [RATIO];

  // data returns one cycle after the strobe; remember which slot it belongs to
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_vld_q <= r_stb_i;
      cap_idx_q <= idx_i;
    end
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[g] <= '0;
      else if (cap_vld_q && cap_idx_q == IW'(g))  slot_q[g] <= r_data_i;
    end
    assign word_o[g*CSR_DW +: CSR_DW] = slot_q[g];
  end
endmodule

// File: rtl/csr_width_dc.sv
module csr_width_dc #(
  parameter int CPU_AW = 6,
  parameter int CPU_DW = 32,
  parameter int CSR_DW = 8,
  parameter int RATIO  = CPU_DW / CSR_DW,
  parameter int IW     = (RATIO > 1) ? $clog2(RATIO) : 1,
  parameter int CSR_AW = CPU_AW + IW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [CPU_AW-1:0] addr_i,
  input  logic [CPU_DW-1:0] wdata_i,
  output logic              ack_o,
  output logic [CPU_DW-1:0] rdata_o,
  output logic [CSR_AW-1:0] csr_addr_o,
  output logic              csr_r_stb_o,
  input  logic [CSR_DW-1:0] csr_r_data_i,
  output logic              csr_w_stb_o,
  output logic [CSR_DW-1:0] csr_w_data_o
);
  logic              issue;
  logic              we_q;
  logic [IW-1:0]     idx;
  logic [CPU_AW-1:0] base;

  csr_dc_seq #(.CPU_AW(CPU_AW), .RATIO(RATIO), .IW(IW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .issue_o (issue),
    .we_o    (we_q),
    .idx_o   (idx),
    .base_o  (base),
    .ack_o   (ack_o)
  );

  // write word is held by the CPU until ack, so it is sliced directly
  csr_dc_wsel #(.CPU_DW(CPU_DW), .CSR_DW(CSR_DW), .RATIO(RATIO), .IW(IW)) u_wsel (
    .wdata_i (wdata_i),
    .idx_i   (idx),
    .chunk_o (csr_w_data_o)
  );

  csr_dc_rasm #(.CPU_DW(CPU_DW), .CSR_DW(CSR_DW), .RATIO(RATIO), .IW(IW)) u_rasm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .r_stb_i  (csr_r_stb_o),
    .idx_i    (idx),
    .r_data_i (csr_r_data_i),
    .word_o   (rdata_o)
  );

  assign csr_addr_o  = CSR_AW'(base) * CSR_AW'(RATIO) + CSR_AW'(idx);
  assign csr_r_stb_o = issue && !we_q;
  assign csr_w_stb_o = issue && we_q;

  AST_ONE_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_r_stb_o && csr_w_stb_o)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csr_r_stb_o || csr_w_stb_o) && $past(csr_r_stb_o || csr_w_stb_o))
      |-> csr_addr_o == $past(csr_addr_o) + 1'b1); // R3
  AST_RD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !csr_w_stb_o) |-> ($past(csr_r_stb_o, 2) && !$past(csr_r_stb_o))); // R7
endmodule

// File: tb/csr_width_dc_tb_top.sv
module csr_width_dc_tb_top;
  localparam int CPU_AW = 6;
  localparam int CPU_DW = 32;
  localparam int CSR_DW = 8;
  localparam int RATIO  = 4;
  localparam int CSR_AW = 8;
  localparam int WIDE_BASE = 9; // 24-bit register at CPU word 9

  typedef struct packed {
    logic              we;
    logic [CSR_AW-1:0] addr;
    logic [CSR_DW-1:0] data;
  } stb_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic we_i = 1'b0;
  logic [CPU_AW-1:0] addr_i = '0;
  logic [CPU_DW-1:0] wdata_i = '0;
  logic ack_o;
  logic [CPU_DW-1:0] rdata_o;
  logic [CSR_AW-1:0] csr_addr_o;
  logic csr_r_stb_o, csr_w_stb_o;
  logic [CSR_DW-1:0] csr_r_data_i, csr_w_data_o;

  always #4 clk_i = ~clk_i;

  csr_width_dc #(.CPU_AW(CPU_AW), .CPU_DW(CPU_DW), .CSR_DW(CSR_DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o), .csr_addr_o(csr_addr_o),
    .csr_r_stb_o(csr_r_stb_o), .csr_r_data_i(csr_r_data_i),
    .csr_w_stb_o(csr_w_stb_o), .csr_w_data_o(csr_w_data_o)
  );

  // register bus model: byte memory, read data one cycle late, plus a 24-bit
  // register whose chunks 0..2 are staged and committed by the chunk-3 write
  logic [CSR_DW-1:0] mem [2**CSR_AW];
  logic [23:0] wide_stage, wide_reg;
  initial for (int i = 0; i < 2**CSR_AW; i++) mem[i] = CSR_DW'(i * 37 + 5);
  always_ff @(posedge clk_i) begin
    if (csr_r_stb_o) csr_r_data_i <= mem[csr_addr_o];
    if (csr_w_stb_o) begin
      mem[csr_addr_o] <= csr_w_data_o;
      if (csr_addr_o == CSR_AW'(WIDE_BASE*RATIO + 0)) wide_stage[7:0]   <= csr_w_data_o;
      if (csr_addr_o == CSR_AW'(WIDE_BASE*RATIO + 1)) wide_stage[15:8]  <= csr_w_data_o;
      if (csr_addr_o == CSR_AW'(WIDE_BASE*RATIO + 2)) wide_stage[23:16] <= csr_w_data_o;
      if (csr_addr_o == CSR_AW'(WIDE_BASE*RATIO + 3)) wide_reg <= wide_stage;
    end
  end

  int checks = 0;
  int fails = 0;
  int stb_cnt = 0;
  bit done = 1'b0;
  stb_t exp_q[$];
  logic [CSR_DW-1:0] exp_mem [2**CSR_AW];
  initial for (int i = 0; i < 2**CSR_AW; i++) exp_mem[i] = CSR_DW'(i * 37 + 5);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected strobe per observed strobe
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R9 no double strobe", 64'(csr_r_stb_o && csr_w_stb_o), 64'd0);
      if (csr_r_stb_o || csr_w_stb_o) begin
        stb_cnt++;
        if (exp_q.size() == 0) begin
          check("R8 unexpected strobe", 64'(csr_addr_o), 64'hFFFF);
        end else begin
          stb_t e;
          e = exp_q.pop_front();
          check("R9 strobe kind", 64'(csr_w_stb_o), 64'(e.we));
          check("R3 chunk address", 64'(csr_addr_o), 64'(e.addr));
          if (e.we) check("R4 chunk data", 64'(csr_w_data_o), 64'(e.data));
        end
      end
    end
  end

  task automatic wait_ack(input int exp_cyc, input string req);
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!ack_o && n < 40);
    check(req, 64'(n), 64'(exp_cyc));
  endtask

  task automatic post_check();
    req_i = 1'b0;
    @(negedge clk_i);
    check("R2 strobe count", 64'(stb_cnt), 64'(RATIO));
    check("R8 single-cycle ack", 64'(ack_o), 64'd0);
    check("R2 all chunks issued", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic cpu_write(input logic [CPU_AW-1:0] a, input logic [CPU_DW-1:0] d);
    for (int i = 0; i < RATIO; i++) begin
      exp_q.push_back('{we: 1'b1, addr: CSR_AW'(a * RATIO + i), data: d[i*CSR_DW +: CSR_DW]});
      exp_mem[a*RATIO + i] = d[i*CSR_DW +: CSR_DW];
    end
    stb_cnt = 0;
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    wait_ack(RATIO, "R6 write ack with last strobe");
    check("R6 ack cycle has write strobe", 64'(csr_w_stb_o), 64'd1);
    post_check();
  endtask

  task automatic cpu_read(input logic [CPU_AW-1:0] a);
    logic [CPU_DW-1:0] exp_w;
    for (int i = 0; i < RATIO; i++) begin
      exp_q.push_back('{we: 1'b0, addr: CSR_AW'(a * RATIO + i), data: '0});
      exp_w[i*CSR_DW +: CSR_DW] = exp_mem[a*RATIO + i];
    end
    stb_cnt = 0;
    req_i = 1'b1; we_i = 1'b0; addr_i = a; wdata_i = 32'hDEAD_BEEF;
    wait_ack(RATIO + 2, "R7 read ack latency");
    check("R5 assembled read word", 64'(rdata_o), 64'(exp_w));
    post_check();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 ack in reset", 64'(ack_o), 64'd0);
    check("R1 strobes in reset", 64'({csr_r_stb_o, csr_w_stb_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R8 idle no strobe", 64'({csr_r_stb_o, csr_w_stb_o, ack_o}), 64'd0);

    cpu_read(6'd0);
    cpu_read(6'd63);
    cpu_write(6'd5, 32'h1122_3344);
    cpu_read(6'd5);
    cpu_write(6'd0, 32'hFFFF_FFFF);
    cpu_write(6'd63, 32'h0000_0000);
    cpu_read(6'd63);
    cpu_read(6'd0);
    // wide register: fourth chunk write commits in the ack cycle
    cpu_write(6'(WIDE_BASE), 32'h00AB_CDEF);
    check("R6 24-bit register committed", 64'(wide_reg), 64'h00AB_CDEF);
    cpu_write(6'(WIDE_BASE), 32'h7712_3456);
    check("R6 24-bit register recommitted", 64'(wide_reg), 64'h0012_3456);
    cpu_read(6'(WIDE_BASE));
    // back-to-back: request raised in the idle cycle right after ack
    cpu_write(6'd20, 32'hA5A5_5A5A);
    cpu_read(6'd20);
    cpu_read(6'd21);

    repeat (4) @(negedge clk_i);
    check("R8 quiet after traffic", 64'({csr_r_stb_o, csr_w_stb_o, ack_o}), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule